// File: doc/BRIEF.md
# Split-Frame Downstream Serial Transmitter

This block sends one downstream frame per start request over a single serial line. The frame carries two halves, a low part and then a high part. Each half can be switched on or off on its own. Each half can also open with its own selection bit, which marks the frame type. A selection bit of 1 marks a command frame. A selection bit of 0, or no selection bit, marks a data frame. After the active bits the line enters a passive gap of at least two frame-clock periods, and no data is driven during that gap. If neither half is enabled, the frame is a passive-time frame that consists of the gap alone.

When a start request is accepted, the block captures both data halves, their lengths, their enables and their selection settings. These values are held for the whole frame. While the emergency-stop input is high at capture, any bit whose substitution-mask bit is set is taken from a fallback word instead of the normal data input. A start request made during a frame is remembered. It launches the next frame as soon as the minimum passive gap has run out. The next frame then follows with no idle cycle in between.

Top module: `splitFrameTx`

## Requirements
- R1: The low half is sent before the high half, and each half is sent least significant bit first, one bit per clock.
- R2: The length of each half is its 4-bit length field plus one, so a half holds 1 to 16 bits.
- R3: When selection insertion is on for an enabled half, that half's selection value is sent for one clock just before the half's first data bit. A value of 1 marks a command frame and 0 marks a data frame.
- R4: A disabled half sends no data bits and no selection bit, and its strobe stays low for the whole frame.
- R5: When both halves are disabled, an accepted start gives a passive-time frame: busy is high for exactly 2 clocks and the serial output stays 0.
- R6: Every frame ends with a passive gap of 2 clocks. During the gap busy stays high, the serial output is 0 and both strobes are low.
- R7: A half's strobe is high exactly while that half's selection bit or data bits are on the line. The two strobes are never high together.
- R8: done is high for one clock only, in the last clock of the passive gap.
- R9: If the emergency stop is high when a start is accepted, each bit whose mask bit is 1 is loaded from the fallback word. Mask bits 0..15 select low-half bits 0..15, and mask bits 16..31 select high-half bits 0..15.
- R10: Data, lengths, enables and selection settings are captured when a start is accepted. Changing these inputs during the frame has no effect on that frame.
- R11: A start request seen while busy and before the last passive clock is held. The next frame then begins in the clock right after the passive gap. A start request that is high in the last passive clock also chains the next frame directly.
- R12: After reset, busy, done, both strobes and the serial output are all 0.
- R13: While not busy, the serial output and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to send a frame |
| lowData | input | 16 | Low-half data bits |
| highData | input | 16 | High-half data bits |
| lowLenM1 | input | 4 | Low-half length minus one |
| highLenM1 | input | 4 | High-half length minus one |
| lowEn | input | 1 | Low half enabled |
| highEn | input | 1 | High half enabled |
| lowSelEn | input | 1 | Insert a selection bit before the low half |
| highSelEn | input | 1 | Insert a selection bit before the high half |
| lowSelVal | input | 1 | Low-half selection bit value |
| highSelVal | input | 1 | High-half selection bit value |
| emgStop | input | 1 | Emergency stop |
| emgMask | input | 32 | Per-bit substitution mask (low half in bits 15..0) |
| fallbackData | input | 32 | Fallback word (low half in bits 15..0) |
| serOut | output | 1 | Serial data line |
| lowStrobe | output | 1 | Low half on the line |
| highStrobe | output | 1 | High half on the line |
| busy | output | 1 | Frame in progress, gap included |
| done | output | 1 | Last clock of the passive gap |

## Verification
The hardest case to reach is a start request that lands inside a running frame. It has to be held across the rest of the active bits and the gap, and then it must launch a new frame in the exact clock the gap ends. Two further cases need care. A request that is still high in the last passive clock must chain the next frame directly. A request raised one clock earlier must be remembered instead. The stimulus reaches these cases by pulsing the request at chosen clocks during a frame, and by holding it high across several frames. A behavioural queue model predicts every clock, including when each frame begins.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LSEL,
    ST_LDAT,
    ST_HSEL,
    ST_HDAT,
    ST_PASS
  } phase_t;

  typedef enum logic [2:0] {
    OUT_ZERO,
    OUT_LSEL,
    OUT_LBIT,
    OUT_HSEL,
    OUT_HBIT
  } outSel_t;

  typedef struct packed {
    logic    load;
    logic    shiftLow;
    logic    shiftHigh;
    outSel_t outSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int MAX_LEN  = 16,
  parameter int PASS_MIN = 2,
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int PCNT_W  = $clog2(PASS_MIN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] lowLenM1,
  input  logic [LEN_W-1:0] highLenM1,
  input  logic             lowEn,
  input  logic             highEn,
  input  logic             lowSelEn,
  input  logic             highSelEn,
  output ctrlStrobes_t     strobes,
  output logic             lowStrobe,
  output logic             highStrobe,
  output logic             busy,
  output logic             done
);

  phase_t            state;
  logic [LEN_W-1:0]  bitCnt;
  logic [PCNT_W-1:0] passCnt;
  logic [LEN_W-1:0]  cfgLowLen, cfgHighLen;
  logic              cfgHighEn, cfgHighSel;
  logic              pending;
  logic              lastPass;
  logic              accept;

  function automatic phase_t entryFor(logic lEn, logic lSel, logic hEn, logic hSel);
    if (lEn)      return lSel ? ST_LSEL : ST_LDAT;
    else if (hEn) return hSel ? ST_HSEL : ST_HDAT;
    else          return ST_PASS;
  endfunction

  assign lastPass = (state == ST_PASS) && (passCnt == PCNT_W'(PASS_MIN - 1));
  assign accept   = ((state == ST_IDLE) && startReq) || (lastPass && (pending || startReq));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      passCnt    <= '0;
      cfgLowLen  <= '0;
      cfgHighLen <= '0;
      cfgHighEn  <= 1'b0;
      cfgHighSel <= 1'b0;
    end else if (accept) begin
      state      <= entryFor(lowEn, lowSelEn, highEn, highSelEn);
      bitCnt     <= '0;
      passCnt    <= '0;
      cfgLowLen  <= lowLenM1;
      cfgHighLen <= highLenM1;
      cfgHighEn  <= highEn;
      cfgHighSel <= highSelEn;
    end else begin
      unique case (state)
        ST_LSEL: begin
          state  <= ST_LDAT;
          bitCnt <= '0;
        end
        ST_LDAT: begin
          if (bitCnt == cfgLowLen) begin
            state  <= entryFor(1'b0, 1'b0, cfgHighEn, cfgHighSel);
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_HSEL: begin
          state  <= ST_HDAT;
          bitCnt <= '0;
        end
        ST_HDAT: begin
          if (bitCnt == cfgHighLen) begin
            state   <= ST_PASS;
            passCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_PASS: begin
          if (lastPass) state <= ST_IDLE;
          else          passCnt <= passCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pending <= 1'b0;
    else if (accept)            pending <= 1'b0;
    else if (busy && startReq)  pending <= 1'b1;
  end

  always_comb begin
    strobes.load      = accept;
    strobes.shiftLow  = (state == ST_LDAT);
    strobes.shiftHigh = (state == ST_HDAT);
    unique case (state)
      ST_LSEL: strobes.outSel = OUT_LSEL;
      ST_LDAT: strobes.outSel = OUT_LBIT;
      ST_HSEL: strobes.outSel = OUT_HSEL;
      ST_HDAT: strobes.outSel = OUT_HBIT;
      default: strobes.outSel = OUT_ZERO;
    endcase
  end

  assign lowStrobe  = (state == ST_LSEL) || (state == ST_LDAT);
  assign highStrobe = (state == ST_HSEL) || (state == ST_HDAT);
  assign busy       = (state != ST_IDLE);
  assign done       = lastPass;

endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int WORD_W = 2 * MAX_LEN
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [MAX_LEN-1:0] lowData,
  input  logic [MAX_LEN-1:0] highData,
  input  logic               lowSelVal,
  input  logic               highSelVal,
  input  logic               emgStop,
  input  logic [WORD_W-1:0]  emgMask,
  input  logic [WORD_W-1:0]  fallbackData,
  output logic               serOut
);

  logic [MAX_LEN-1:0] lowLoad, highLoad;
  logic [MAX_LEN-1:0] lowSh, highSh;
  logic               lowSelQ, highSelQ;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_subst
    assign lowLoad[i]  = (emgStop && emgMask[i])           ? fallbackData[i]           : lowData[i];
    assign highLoad[i] = (emgStop && emgMask[MAX_LEN + i])  ? fallbackData[MAX_LEN + i] : highData[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowSh    <= '0;
      highSh   <= '0;
      lowSelQ  <= 1'b0;
      highSelQ <= 1'b0;
    end else if (strobes.load) begin
      lowSh    <= lowLoad;
      highSh   <= highLoad;
      lowSelQ  <= lowSelVal;
      highSelQ <= highSelVal;
    end else begin
      if (strobes.shiftLow)  lowSh  <= lowSh >> 1;
      if (strobes.shiftHigh) highSh <= highSh >> 1;
    end
  end

  always_comb begin
    unique case (strobes.outSel)
      OUT_LSEL: serOut = lowSelQ;
      OUT_LBIT: serOut = lowSh[0];
      OUT_HSEL: serOut = highSelQ;
      OUT_HBIT: serOut = highSh[0];
      default:  serOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/splitFrameTx.sv
module splitFrameTx
  import sft_pkg::*;
#(
  parameter int MAX_LEN  = 16,
  parameter int PASS_MIN = 2,
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int WORD_W  = 2 * MAX_LEN
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [MAX_LEN-1:0] lowData,
  input  logic [MAX_LEN-1:0] highData,
  input  logic [LEN_W-1:0]   lowLenM1,
  input  logic [LEN_W-1:0]   highLenM1,
  input  logic               lowEn,
  input  logic               highEn,
  input  logic               lowSelEn,
  input  logic               highSelEn,
  input  logic               lowSelVal,
  input  logic               highSelVal,
  input  logic               emgStop,
  input  logic [WORD_W-1:0]  emgMask,
  input  logic [WORD_W-1:0]  fallbackData,
  output logic               serOut,
  output logic               lowStrobe,
  output logic               highStrobe,
  output logic               busy,
  output logic               done
);

  ctrlStrobes_t strobes;

  sft_ctrl #(.MAX_LEN(MAX_LEN), .PASS_MIN(PASS_MIN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .lowLenM1   (lowLenM1),
    .highLenM1  (highLenM1),
    .lowEn      (lowEn),
    .highEn     (highEn),
    .lowSelEn   (lowSelEn),
    .highSelEn  (highSelEn),
    .strobes    (strobes),
    .lowStrobe  (lowStrobe),
    .highStrobe (highStrobe),
    .busy       (busy),
    .done       (done)
  );

  sft_datapath #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .lowData      (lowData),
    .highData     (highData),
    .lowSelVal    (lowSelVal),
    .highSelVal   (highSelVal),
    .emgStop      (emgStop),
    .emgMask      (emgMask),
    .fallbackData (fallbackData),
    .serOut       (serOut)
  );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rstN,
  input logic serOut,
  input logic lowStrobe,
  input logic highStrobe,
  input logic busy,
  input logic done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(lowStrobe && highStrobe)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serOut && !lowStrobe && !highStrobe)); // R13

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !serOut && !lowStrobe && !highStrobe)); // R8

  AST_GAP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!$past(lowStrobe) && !$past(highStrobe) && $past(busy))); // R6

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (lowStrobe || highStrobe) |-> busy); // R6

endmodule

bind splitFrameTx sft_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .serOut     (serOut),
  .lowStrobe  (lowStrobe),
  .highStrobe (highStrobe),
  .busy       (busy),
  .done       (done)
);

// File: tb/splitFrameTx_bench.sv
module splitFrameTx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] lowData = '0, highData = '0;
  logic [3:0]  lowLenM1 = '0, highLenM1 = '0;
  logic        lowEn = 0, highEn = 0, lowSelEn = 0, highSelEn = 0;
  logic        lowSelVal = 0, highSelVal = 0, emgStop = 0;
  logic [31:0] emgMask = '0, fallbackData = '0;
  logic        serOut, lowStrobe, highStrobe, busy, done;

  always #2.5 clk = ~clk;

  splitFrameTx u_splitFrameTx (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .lowData(lowData), .highData(highData),
    .lowLenM1(lowLenM1), .highLenM1(highLenM1),
    .lowEn(lowEn), .highEn(highEn), .lowSelEn(lowSelEn), .highSelEn(highSelEn),
    .lowSelVal(lowSelVal), .highSelVal(highSelVal),
    .emgStop(emgStop), .emgMask(emgMask), .fallbackData(fallbackData),
    .serOut(serOut), .lowStrobe(lowStrobe), .highStrobe(highStrobe),
    .busy(busy), .done(done)
  );

  typedef struct { bit s; bit l; bit h; bit d; } step_t;
  step_t q[$];
  bit    pend = 0;
  int    checks = 0, errors = 0;
  string curReq = "R1";
  bit    finished = 0;
  int    doneCnt = 0, busyCnt = 0, lowCnt = 0, highCnt = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void pushStep(bit s, bit l, bit h, bit d);
    step_t st;
    st.s = s; st.l = l; st.h = h; st.d = d;
    q.push_back(st);
  endfunction

  function automatic void buildFrame();
    if (lowEn) begin
      if (lowSelEn) pushStep(lowSelVal, 1, 0, 0);
      for (int i = 0; i <= int'(lowLenM1); i++)
        pushStep((emgStop && emgMask[i]) ? fallbackData[i] : lowData[i], 1, 0, 0);
    end
    if (highEn) begin
      if (highSelEn) pushStep(highSelVal, 0, 1, 0);
      for (int i = 0; i <= int'(highLenM1); i++)
        pushStep((emgStop && emgMask[16+i]) ? fallbackData[16+i] : highData[i], 0, 1, 0);
    end
    pushStep(0, 0, 0, 0);
    pushStep(0, 0, 0, 1);
  endfunction

  // behavioural reference: queue of expected line states, front = current clock
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      pend = 0;
    end else if (q.size() > 0) begin
      bit isLast;
      isLast = (q.size() == 1);
      void'(q.pop_front());
      if (isLast) begin
        if (pend || startReq) begin
          buildFrame();
          pend = 0;
        end
      end else if (startReq) begin
        pend = 1;
      end
    end else if (startReq) begin
      buildFrame();
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      step_t e;
      if (q.size() > 0) e = q[0];
      else begin e.s = 0; e.l = 0; e.h = 0; e.d = 0; end
      check(serOut == e.s, (q.size() > 0) ? curReq : "R13", "serOut", serOut, e.s);
      check(lowStrobe == e.l, "R7", "lowStrobe", lowStrobe, e.l);
      check(highStrobe == e.h, "R7", "highStrobe", highStrobe, e.h);
      check(busy == (q.size() > 0), "R6", "busy", busy, q.size() > 0);
      check(done == e.d, "R8", "done", done, e.d);
      doneCnt += done;
      busyCnt += busy;
      lowCnt  += lowStrobe;
      highCnt += highStrobe;
    end
  end

  task automatic setup(bit lE, bit hE, bit lS, bit hS, bit lV, bit hV,
                       logic [3:0] lL, logic [3:0] hL, logic [15:0] lD, logic [15:0] hD);
    lowEn = lE; highEn = hE; lowSelEn = lS; highSelEn = hS;
    lowSelVal = lV; highSelVal = hV; lowLenM1 = lL; highLenM1 = hL;
    lowData = lD; highData = hD;
  endtask

  task automatic clearCounts();
    doneCnt = 0; busyCnt = 0; lowCnt = 0; highCnt = 0;
  endtask

  task automatic fire();
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0;
  endtask

  task automatic drain();
    for (int n = 0; n < 200 && (busy || q.size() > 0); n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values
    check(!busy && !done && !serOut && !lowStrobe && !highStrobe, "R12", "outputs in reset",
          {busy, done, serOut, lowStrobe, highStrobe}, 0);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(!busy && !serOut, "R12", "outputs after reset", {busy, serOut}, 0);

    // R1: order and LSB first
    curReq = "R1";
    setup(1, 1, 0, 0, 0, 0, 4'd7, 4'd3, 16'h00B4, 16'h0009);
    clearCounts(); fire(); drain();
    check(lowCnt == 8 && highCnt == 4, "R1", "strobe cycles low*100+high", lowCnt*100+highCnt, 804);
    setup(1, 1, 0, 0, 0, 0, 4'd5, 4'd5, 16'h0021, 16'h001E);
    fire(); drain();

    // R2: lengths 1 and 16
    curReq = "R2";
    setup(1, 1, 0, 0, 0, 0, 4'd0, 4'd15, 16'h0001, 16'hA5C3);
    clearCounts(); fire(); drain();
    check(lowCnt == 1 && highCnt == 16, "R2", "strobe cycles low*100+high", lowCnt*100+highCnt, 116);
    setup(1, 1, 0, 0, 0, 0, 4'd15, 4'd0, 16'h7E81, 16'h0000);
    fire(); drain();

    // R3: selection bits, command and data marking
    curReq = "R3";
    setup(1, 1, 1, 1, 1, 0, 4'd2, 4'd2, 16'h0002, 16'h0005);
    clearCounts(); fire(); drain();
    check(lowCnt == 4 && highCnt == 4, "R3", "strobe cycles with sel", lowCnt*100+highCnt, 404);
    setup(1, 1, 1, 0, 0, 1, 4'd1, 4'd1, 16'h0003, 16'h0003);
    fire(); drain();

    // R4: one half disabled
    curReq = "R4";
    setup(0, 1, 1, 1, 1, 1, 4'd4, 4'd2, 16'hFFFF, 16'h0006);
    clearCounts(); fire(); drain();
    check(lowCnt == 0, "R4", "low strobe cycles with low disabled", lowCnt, 0);
    setup(1, 0, 0, 1, 0, 1, 4'd2, 4'd9, 16'h0005, 16'hFFFF);
    clearCounts(); fire(); drain();
    check(highCnt == 0, "R4", "high strobe cycles with high disabled", highCnt, 0);

    // R5: passive-time frame
    curReq = "R5";
    setup(0, 0, 1, 1, 1, 1, 4'd3, 4'd3, 16'hFFFF, 16'hFFFF);
    clearCounts(); fire(); drain();
    check(busyCnt == 2 && doneCnt == 1, "R5", "busy*10+done", busyCnt*10+doneCnt, 21);

    // R9: emergency substitution
    curReq = "R9";
    setup(1, 1, 0, 0, 0, 0, 4'd7, 4'd7, 16'h00FF, 16'h0000);
    emgStop = 1; emgMask = 32'h000F_00F0; fallbackData = 32'h00AA_0000;
    fire(); emgStop = 0;
    drain();
    emgMask = 32'hFFFF_FFFF; fallbackData = 32'h1234_5678;
    fire(); drain();   // mask set but stop low: no substitution

    // R10: inputs changed mid-frame
    curReq = "R10";
    setup(1, 1, 1, 1, 1, 1, 4'd5, 4'd5, 16'h0015, 16'h002A);
    fire();
    setup(0, 0, 0, 0, 0, 0, 4'd0, 4'd0, 16'hFFFF, 16'hFFFF);
    emgStop = 1;
    drain();
    emgStop = 0;

    // R11: request during frame, then continuous request
    curReq = "R11";
    setup(1, 1, 0, 0, 0, 0, 4'd3, 4'd3, 16'h0009, 16'h0006);
    clearCounts(); fire();
    repeat (3) @(negedge clk);
    startReq = 1; lowData = 16'h000F;
    @(negedge clk) startReq = 0;
    drain();
    check(doneCnt == 2, "R11", "frames from held request", doneCnt, 2);
    setup(1, 0, 1, 0, 1, 0, 4'd1, 4'd0, 16'h0002, 16'h0000);
    clearCounts();
    @(negedge clk) startReq = 1;
    repeat (20) @(negedge clk);
    startReq = 0;
    drain();
    check(doneCnt >= 4, "R11", "back-to-back frames", doneCnt, 4);
    // request one clock before the gap ends is held
    setup(1, 0, 0, 0, 0, 0, 4'd0, 4'd0, 16'h0001, 16'h0000);
    clearCounts(); fire();
    @(negedge clk) startReq = 1;   // first gap clock
    @(negedge clk) startReq = 0;
    drain();
    check(doneCnt == 2, "R11", "frames from gap request", doneCnt, 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule